// File: doc/BRIEF.md
# SDRAM Mode-Driven Command Issuer

This block sits between a host bus and the command pins of one rank of single-data-rate SDRAM. A three-bit mode input decides what a host write does. In normal mode, reads and writes become full row cycles: activate, then a column read or write, then a single-bank precharge. In the four special modes, a host write sends one fixed command to the memory and moves no data. The commands are NOP, precharge of all banks, load of the device mode register, and auto-refresh. Software therefore runs the whole power-up sequence itself. It selects a mode, performs one write, and waits for the ready pulse before the next step.

The timing fields tRC, tRP, tRCD, tRAS and CAS latency come in on configuration inputs. A zero in any of them is treated as one. A refresh interval timer reloads from a count input. It raises a refresh request that the block serves between normal-mode accesses. The host address is split, from the top down, into bank, row and column. The row, column and bank widths are parameters.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: Commands are driven as {cs_n,ras_n,cas_n,we_n}: NOP 0111, ACT 0011, READ 0101, WRITE 0100, PRE 0010, REF 0001, LMR 0000. The mode values are: 0 normal, 1 NOP, 2 all-bank precharge, 3 load mode register, 4 auto-refresh. Values 5 to 7 behave as mode 1.
- R2: In a special mode, a host write drives exactly one command of the selected type for one cycle. The command appears one cycle after acceptance. host_ready pulses for one cycle a wait W later: 1 for NOP, tRP for PRE, tRC for REF, TMRD for LMR. So ready appears W+1 cycles after acceptance.
- R3: In a special mode, a host read issues no command. host_ready pulses in the cycle after acceptance.
- R4: All-bank PRE drives A10=1 and BA=0. LMR drives A=host_addr[12:0] and BA=host_addr[14:13].
- R5: In normal mode, ACT appears one cycle after acceptance. BA is host_addr[23:22] and A is host_addr[21:9].
- R6: READ or WRITE follows ACT after tRCD cycles. A carries host_addr[8:0], with A10=0.
- R7: A single-bank PRE (A10=0, BA = the access bank) is issued once two conditions hold. First, max(1,CAS latency) cycles have passed after a READ, or TWR cycles after a WRITE. Second, at least tRAS cycles have passed since ACT.
- R8: After a normal access, host_ready pulses tRP cycles after its PRE.
- R9: In mode 0 with a nonzero count N, refresh commands recur every N cycles while the host is idle.
- R10: No refresh is issued while the count is 0 or the mode is nonzero. A pending request is dropped when the mode leaves 0.
- R11: A refresh is never issued while a row is open. A refresh request pending at an access boundary is served before the next ACT.
- R12: The next command after REF comes at least tRC cycles later. The next command after any PRE comes at least tRP cycles later.
- R13: During and after reset, the block drives NOP with A=0 and BA=0, and host_ready is low.
- R14: A timing input of zero is treated as one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Command mode select |
| cfg_ref_count | input | 12 | Refresh interval in cycles, 0 disables |
| cfg_trc | input | 4 | Refresh-to-command cycles |
| cfg_trp | input | 4 | Precharge-to-command cycles |
| cfg_trcd | input | 4 | Activate-to-column cycles |
| cfg_tras | input | 4 | Activate-to-precharge minimum |
| cfg_cas_lat | input | 2 | CAS latency |
| host_req | input | 1 | Access request, held until host_ready |
| host_we | input | 1 | 1 write, 0 read |
| host_addr | input | 24 | Bank, row, column address |
| host_ready | output | 1 | One-cycle completion pulse |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 13 | Address bus |

## Verification
The embedded properties assume three things about the inputs. Software changes cfg_mode and the timing fields only while no access is in flight. host_req is held until host_ready is seen and then dropped in the same cycle. The bench follows these rules. Every mode and timing change is made at a falling edge after the last ready pulse, and each request is lowered at the falling edge where ready is first observed. The mode-matching checks use a stable-mode guard. As a result, a command launched just before a mode change is never judged against the new mode.

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer #(
  parameter int COL_W  = 9,
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int A_W    = 13,
  parameter int REF_W  = 12,
  parameter int T_W    = 4,
  parameter int TMRD   = 2,
  parameter int TWR    = 2,
  localparam int ADDR_W = COL_W + ROW_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_mode,
  input  logic [REF_W-1:0]  cfg_ref_count,
  input  logic [T_W-1:0]    cfg_trc,
  input  logic [T_W-1:0]    cfg_trp,
  input  logic [T_W-1:0]    cfg_trcd,
  input  logic [T_W-1:0]    cfg_tras,
  input  logic [1:0]        cfg_cas_lat,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              host_ready,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BANK_W-1:0] sd_ba,
  output logic [A_W-1:0]    sd_a
);

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD  = 4'b0101,
                         C_WR  = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_LMR = 4'b0000;
  localparam logic [A_W-1:0] A10     = A_W'(1) << 10;
  localparam logic [T_W-1:0] WR_WAIT = T_W'(TWR  > 0 ? TWR  - 1 : 0);
  localparam logic [T_W-1:0] MR_WAIT = T_W'(TMRD > 0 ? TMRD - 1 : 0);

  typedef enum logic [2:0] {ST_IDLE, ST_ACT, ST_RW, ST_PRE, ST_HOLD} state_t;

  function automatic logic [T_W-1:0] at_least1(input logic [T_W-1:0] v);
    return (v == '0) ? T_W'(1) : v;
  endfunction

  state_t             state_q;
  logic [3:0]         cmd_q;
  logic [A_W-1:0]     a_q;
  logic [BANK_W-1:0]  ba_q;
  logic [T_W-1:0]     cnt_q, ras_q;
  logic [COL_W-1:0]   col_q;
  logic               we_q, host_op_q, ready_q, pend_q, en_q;
  logic [REF_W-1:0]   tmr_q;

  wire ref_en = (cfg_mode == 3'd0) && (cfg_ref_count != '0);
  wire [T_W-1:0] cas_eff = at_least1(T_W'(cfg_cas_lat));

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_a       = a_q;
  assign sd_ba      = ba_q;
  assign host_ready = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  cmd_q <= C_NOP;  a_q <= '0;  ba_q <= '0;
      cnt_q <= '0;  ras_q <= '0;  col_q <= '0;  we_q <= 1'b0;
      host_op_q <= 1'b0;  ready_q <= 1'b0;  pend_q <= 1'b0;
      en_q <= 1'b0;  tmr_q <= '0;
    end else begin
      cmd_q   <= C_NOP;
      ready_q <= 1'b0;
      if (ras_q != '0) ras_q <= ras_q - 1'b1;

      case (state_q)
        ST_IDLE: begin
          if (pend_q && cfg_mode == 3'd0) begin
            cmd_q <= C_REF;  a_q <= '0;  ba_q <= '0;
            cnt_q <= at_least1(cfg_trc) - 1'b1;
            host_op_q <= 1'b0;  pend_q <= 1'b0;
            state_q <= ST_HOLD;
          end else if (host_req) begin
            if (cfg_mode == 3'd0) begin
              cmd_q <= C_ACT;
              ba_q  <= host_addr[ADDR_W-1 -: BANK_W];
              a_q   <= A_W'(host_addr[COL_W+ROW_W-1:COL_W]);
              col_q <= host_addr[COL_W-1:0];
              we_q  <= host_we;
              ras_q <= at_least1(cfg_tras);
              cnt_q <= at_least1(cfg_trcd) - 1'b1;
              state_q <= ST_ACT;
            end else if (!host_we) begin
              ready_q <= 1'b1;
            end else begin
              host_op_q <= 1'b1;
              state_q   <= ST_HOLD;
              case (cfg_mode)
                3'd2: begin
                  cmd_q <= C_PRE;  a_q <= A10;  ba_q <= '0;
                  cnt_q <= at_least1(cfg_trp) - 1'b1;
                end
                3'd3: begin
                  cmd_q <= C_LMR;
                  a_q   <= host_addr[A_W-1:0];
                  ba_q  <= host_addr[A_W+BANK_W-1:A_W];
                  cnt_q <= MR_WAIT;
                end
                3'd4: begin
                  cmd_q <= C_REF;  a_q <= '0;  ba_q <= '0;
                  cnt_q <= at_least1(cfg_trc) - 1'b1;
                end
                default: cnt_q <= '0;
              endcase
            end
          end
        end
        ST_ACT: begin
          if (cnt_q == '0) begin
            cmd_q <= we_q ? C_WR : C_RD;
            a_q   <= A_W'(col_q) & ~A10;
            cnt_q <= we_q ? WR_WAIT : cas_eff - 1'b1;
            state_q <= ST_RW;
          end else cnt_q <= cnt_q - 1'b1;
        end
        ST_RW: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (ras_q <= T_W'(1)) begin
            cmd_q <= C_PRE;  a_q <= '0;
            cnt_q <= at_least1(cfg_trp) - 1'b1;
            state_q <= ST_PRE;
          end
        end
        ST_PRE, ST_HOLD: begin
          if (cnt_q == '0) begin
            ready_q <= (state_q == ST_PRE) || host_op_q;
            state_q <= ST_IDLE;
          end else cnt_q <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase

      en_q <= ref_en;
      if (!ref_en) pend_q <= 1'b0;
      else if (!en_q) tmr_q <= cfg_ref_count - 1'b1;
      else if (tmr_q == '0) begin
        pend_q <= 1'b1;
        tmr_q  <= cfg_ref_count - 1'b1;
      end else tmr_q <= tmr_q - 1'b1;
    end
  end

  logic [7:0] since_q, act_since_q;
  logic [3:0] last_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;  act_since_q <= '0;  last_q <= C_NOP;
    end else begin
      if (cmd_q != C_NOP) begin since_q <= 8'd1; last_q <= cmd_q; end
      else if (since_q != 8'hFF) since_q <= since_q + 8'd1;
      if (cmd_q == C_ACT) act_since_q <= 8'd1;
      else if (act_since_q != 8'hFF) act_since_q <= act_since_q + 8'd1;
    end
  end

  assert_ref_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != C_NOP && last_q == C_REF) |-> since_q >= 8'(at_least1(cfg_trc)));
  assert_pre_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q != C_NOP && last_q == C_PRE) |-> since_q >= 8'(at_least1(cfg_trp)));
  assert_tras_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == C_PRE && !sd_a[10]) |-> act_since_q >= 8'(at_least1(cfg_tras)));
  assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);
  assert_nop_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode inside {3'd1, 3'd5, 3'd6, 3'd7} && $stable(cfg_mode)) |-> cmd_q == C_NOP);
  assert_lmr_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 3'd3 && $stable(cfg_mode) && cmd_q != C_NOP) |-> cmd_q == C_LMR);

endmodule

// File: tb/test_sdram_cmd_issuer.sv
module test_sdram_cmd_issuer;
  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_LMR = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] cfg_mode = 3'd0;
  logic [11:0] cfg_ref_count = '0;
  logic [3:0] cfg_trc = 4'd7, cfg_trp = 4'd3, cfg_trcd = 4'd2, cfg_tras = 4'd5;
  logic [1:0] cfg_cas_lat = 2'd2;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [23:0] host_addr = '0;
  logic host_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [1:0] sd_ba;
  logic [12:0] sd_a;

  always #2 clk = ~clk;

  sdram_cmd_issuer i_sdram_cmd_issuer (
    .clk, .rst_n, .cfg_mode, .cfg_ref_count, .cfg_trc, .cfg_trp, .cfg_trcd,
    .cfg_tras, .cfg_cas_lat, .host_req, .host_we, .host_addr, .host_ready,
    .sd_cs_n, .sd_ras_n, .sd_cas_n, .sd_we_n, .sd_ba, .sd_a);

  wire [3:0] cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // bus monitor: refresh placement and command spacing
  int cyc = 0, last_cyc = 0, last_ref_cyc = 0, ref_n = 0, ref_gap = 0;
  logic [3:0] last_kind = C_NOP;
  bit row_open = 0;
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (cmd != C_NOP) begin
      if (last_kind == C_REF) check(cyc - last_cyc >= eff(cfg_trc), "R12 gap after REF", cyc - last_cyc, eff(cfg_trc));
      if (last_kind == C_PRE) check(cyc - last_cyc >= eff(cfg_trp), "R12 gap after PRE", cyc - last_cyc, eff(cfg_trp));
      if (cmd == C_REF) begin
        check(!row_open, "R11 REF with open row", row_open, 0);
        ref_n++;
        ref_gap = cyc - last_ref_cyc;
        last_ref_cyc = cyc;
      end
      if (cmd == C_ACT) row_open = 1;
      if (cmd == C_PRE) row_open = 0;
      last_kind = cmd;
      last_cyc  = cyc;
    end
  end

  int op_n, op_lat;
  logic [3:0] op_cmd [8];
  int op_k [8];
  logic [12:0] op_a [8];
  logic [1:0] op_ba [8];

  task automatic run_op(input logic we, input logic [23:0] addr);
    op_n = 0; op_lat = 0;
    host_we = we; host_addr = addr; host_req = 1'b1;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (cmd != C_NOP && op_n < 8) begin
        op_cmd[op_n] = cmd; op_k[op_n] = k; op_a[op_n] = sd_a; op_ba[op_n] = sd_ba;
        op_n++;
      end
      if (host_ready) begin op_lat = k; break; end
    end
    host_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  typedef struct packed {
    logic [2:0] mode; logic we; logic [23:0] addr; logic [3:0] cmd;
    logic [1:0] n; logic [12:0] a; logic [1:0] ba; logic [7:0] lat;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{3'd1, 1'b1, 24'h000123, C_NOP, 2'd0, 13'h0000, 2'd0, 8'd2},
    '{3'd2, 1'b1, 24'h000456, C_PRE, 2'd1, 13'h0400, 2'd0, 8'd4},
    '{3'd4, 1'b1, 24'h000789, C_REF, 2'd1, 13'h0000, 2'd0, 8'd8},
    '{3'd3, 1'b1, 24'h000032, C_LMR, 2'd1, 13'h0032, 2'd0, 8'd3},
    '{3'd3, 1'b1, 24'h004023, C_LMR, 2'd1, 13'h0023, 2'd2, 8'd3},
    '{3'd6, 1'b1, 24'h000011, C_NOP, 2'd0, 13'h0000, 2'd0, 8'd2},
    '{3'd2, 1'b0, 24'h000000, C_NOP, 2'd0, 13'h0000, 2'd0, 8'd1},
    '{3'd4, 1'b0, 24'h000000, C_NOP, 2'd0, 13'h0000, 2'd0, 8'd1}
  };

  task automatic check_access(input string tag, input int pre_k, input int lat,
                              input logic [3:0] rw, input logic [23:0] addr);
    check(op_n == 3, {tag, " R5 command count"}, op_n, 3);
    check(op_cmd[0] == C_ACT && op_k[0] == 1, {tag, " R5 ACT timing"}, op_k[0], 1);
    check(op_ba[0] == addr[23:22] && op_a[0] == addr[21:9], {tag, " R5 bank/row"}, op_a[0], addr[21:9]);
    check(op_cmd[1] == rw && op_k[1] == 3, {tag, " R6 column cmd timing"}, op_k[1], 3);
    check(op_a[1] == 13'(addr[8:0]), {tag, " R6 column address A10=0"}, op_a[1], addr[8:0]);
    check(op_cmd[2] == C_PRE && op_k[2] == pre_k, {tag, " R7 PRE timing"}, op_k[2], pre_k);
    check(op_a[2][10] == 1'b0 && op_ba[2] == addr[23:22], {tag, " R7 single-bank PRE"}, op_ba[2], addr[23:22]);
    check(op_lat == lat, {tag, " R8 ready after tRP"}, op_lat, lat);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cmd == C_NOP && !host_ready && sd_a == 0 && sd_ba == 0, "R13 in reset", cmd, C_NOP);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(cmd == C_NOP && !host_ready && sd_a == 0 && sd_ba == 0, "R13 after reset", cmd, C_NOP);

    foreach (VECS[i]) begin
      cfg_mode = VECS[i].mode;
      @(negedge clk);
      run_op(VECS[i].we, VECS[i].addr);
      check(op_n == VECS[i].n, VECS[i].we ? "R2 one command per write" : "R3 read issues nothing", op_n, VECS[i].n);
      if (VECS[i].n == 1) begin
        check(op_cmd[0] == VECS[i].cmd && op_k[0] == 1, "R1 command encoding", op_cmd[0], VECS[i].cmd);
        check(op_a[0] == VECS[i].a && op_ba[0] == VECS[i].ba, "R4 address/bank", op_a[0], VECS[i].a);
      end
      check(op_lat == VECS[i].lat, VECS[i].mode > 4 ? "R1 invalid mode as NOP" : "R2 ready latency", op_lat, VECS[i].lat);
    end

    cfg_mode = 3'd2; cfg_trp = 4'd0;
    @(negedge clk);
    run_op(1'b1, 24'h0);
    check(op_lat == 2, "R14 zero tRP as one", op_lat, 2);
    cfg_trp = 4'd3; cfg_mode = 3'd0;
    @(negedge clk);

    run_op(1'b1, {2'd2, 13'h01A5, 9'h03C});
    check_access("write tRAS5", 6, 9, C_WR, {2'd2, 13'h01A5, 9'h03C});
    cfg_tras = 4'd2;
    @(negedge clk);
    run_op(1'b1, {2'd3, 13'h1F00, 9'h155});
    check_access("write tRAS2", 5, 8, C_WR, {2'd3, 13'h1F00, 9'h155});
    cfg_cas_lat = 2'd3;
    @(negedge clk);
    run_op(1'b0, {2'd1, 13'h0007, 9'h1FF});
    check_access("read CL3", 6, 9, C_RD, {2'd1, 13'h0007, 9'h1FF});
    cfg_tras = 4'd5; cfg_cas_lat = 2'd2;

    ref_n = 0;
    cfg_ref_count = 12'd20;
    repeat (70) @(negedge clk);
    check(ref_n >= 2, "R9 refresh count", ref_n, 3);
    check(ref_gap == 20, "R9 refresh interval", ref_gap, 20);

    cfg_ref_count = 12'd0; ref_n = 0;
    repeat (60) @(negedge clk);
    check(ref_n == 0, "R10 count zero disables", ref_n, 0);
    cfg_ref_count = 12'd20; cfg_mode = 3'd1;
    repeat (60) @(negedge clk);
    check(ref_n == 0, "R10 special mode disables", ref_n, 0);

    cfg_mode = 3'd0; cfg_ref_count = 12'd25; ref_n = 0;
    @(negedge clk);
    for (int j = 0; j < 8; j++) begin
      run_op(1'b1, {2'(j), 13'(j * 3), 9'(j * 5)});
      check(op_lat != 0, "R11 access completes", op_lat, 1);
      for (int m = 1; m < op_n; m++)
        check(op_cmd[m] != C_REF, "R11 REF before ACT", op_cmd[m], C_ACT);
    end
    check(ref_n >= 1, "R11 refresh served between accesses", ref_n, 1);

    cfg_ref_count = 12'd0;
    repeat (10) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule